// File: doc/BRIEF.md
# Ternary Match Array with Pair-Gated Search Mask

This block is a small ternary content-addressable array. Every row holds a value word and a care word; a care bit of 0 turns that stored bit into a wildcard. When a search is issued, the key is compared against all rows at once. The lowest-numbered matching entry is reported together with a hit flag and a flag that says more than one entry matched. Rows are loaded through a plain synchronous write port.

A global search mask filters the key during search only. It has one bit per aligned pair of key bits, so a single key bit can never be excluded on its own. An option input joins each even/odd row pair into one entry of twice the width. This halves the number of entries, and the global mask then covers the full double-width key. Results are registered and appear two cycles after the search. A single serial flag output carries the hit indication in the first result cycle and the multiple-match indication in the cycle after.

Top module: `tcam_pair_search`

## Requirements
- R1: A write with `wr_en` high at a rising edge stores `wr_value` and `wr_care` in row `wr_addr`, and every later search compares against the new contents.
- R2: Where a row's care bit is 0, that bit matches either key value. Where it is 1, the key bit must equal the stored bit.
- R3: Global mask bit i (`gm_wr_data[i]`, written with `gm_wr_en`) gates key bits 2i and 2i+1 together. A 1 makes the pair take part in the compare and a 0 excludes it. The mask resets to all ones.
- R4: The global mask has no effect on row writes. A row written while every mask bit is 0 still stores its full value.
- R5: When several entries match, `res_index` is the lowest-numbered matching entry.
- R6: `res_multi` is 1 exactly when two or more entries match, and it never rises without `res_hit`.
- R7: A search with `srch_en` high in cycle t produces a result with `res_valid` high in cycle t+2 only. Nothing is valid in cycle t+1.
- R8: A search with no match gives `res_hit` = 0, `res_multi` = 0 and `res_index` = 0.
- R9: `res_flag` equals the hit indication while `res_valid` is high, equals the multiple-match indication of that result in the following cycle, and is 0 otherwise.
- R10: With `cfg_wide` = 1, rows 2j (key bits [KEY_W-1:0]) and 2j+1 (key bits [2*KEY_W-1:KEY_W]) form entry j. Entry j matches only if both halves match, and the reported index is j. With `cfg_wide` = 0, only key bits [KEY_W-1:0] and mask bits [KEY_W/2-1:0] are used.
- R11: After reset, every row holds value 0 with all care bits 1, and all result outputs are 0.
- R12: A write and a search in the same cycle: the search sees the row contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1: double-width entries from row pairs; 0: one row per entry |
| gm_wr_en | input | 1 | Load the global search mask |
| gm_wr_data | input | KEY_W | New global mask, one bit per key bit pair |
| wr_en | input | 1 | Row write strobe |
| wr_addr | input | $clog2(ROWS) | Row to write |
| wr_value | input | KEY_W | Stored value bits |
| wr_care | input | KEY_W | Stored care bits (0 = wildcard) |
| srch_en | input | 1 | Issue a search |
| srch_key | input | 2*KEY_W | Search key (upper half used in wide mode only) |
| res_valid | output | 1 | First result cycle |
| res_hit | output | 1 | At least one entry matched |
| res_multi | output | 1 | Two or more entries matched |
| res_index | output | $clog2(ROWS) | Lowest matching entry |
| res_flag | output | 1 | Serial flag: hit, then multiple-match |

## Verification
The hardest condition to reach is a write landing on the same clock edge as a search of that row. The stimulus drives both strobes in one cycle with a key that matches only the new contents, then repeats the search alone. The first search must miss and the second must hit. Pair gating is shown by clearing one mask bit and probing with a key that differs from a row only in the odd bit of that pair. The write-under-zero-mask case loads a row while the mask is all zeros, restores the mask, and then looks for an exact, single hit.

// File: rtl/tcam_pair_pkg.sv
package tcam_pair_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_HIT   = 2'd1,
      PH_MULTI = 2'd2
   } flag_phase_e;

   function automatic int unsigned addr_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/tcam_gmask_expand.sv
module tcam_gmask_expand #(
   parameter int GM_W = 16
) (
   input  logic [GM_W-1:0]   gm,
   output logic [2*GM_W-1:0] bit_en
);
   for (genvar i = 0; i < GM_W; i++) begin : g_pair
      assign bit_en[2*i]   = gm[i];
      assign bit_en[2*i+1] = gm[i];
   end
endmodule

// File: rtl/tcam_row_bank.sv
module tcam_row_bank #(
   parameter int ROWS  = 32,
   parameter int KEY_W = 16,
   parameter int AW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [KEY_W-1:0]  wr_value,
   input  logic [KEY_W-1:0]  wr_care,
   input  logic [2*KEY_W-1:0] key,
   input  logic [2*KEY_W-1:0] bit_en,
   input  logic              wide,
   output logic [ROWS-1:0]   row_hit
);
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [KEY_W-1:0] val_q;
      logic [KEY_W-1:0] care_q;
      logic [KEY_W-1:0] key_sel;
      logic [KEY_W-1:0] en_sel;
      logic [KEY_W-1:0] bit_ok;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q  <= '0;
            care_q <= '1;
         end else if (wr_en && (wr_addr == AW'(r))) begin
            val_q  <= wr_value;
            care_q <= wr_care;
         end
      end

      if ((r % 2) == 1) begin : g_odd
         always_comb begin
            if (wide) begin
               key_sel = key[2*KEY_W-1:KEY_W];
               en_sel  = bit_en[2*KEY_W-1:KEY_W];
            end else begin
               key_sel = key[KEY_W-1:0];
               en_sel  = bit_en[KEY_W-1:0];
            end
         end
      end else begin : g_even
         assign key_sel = key[KEY_W-1:0];
         assign en_sel  = bit_en[KEY_W-1:0];
      end

      assign bit_ok     = ~en_sel | ~care_q | ~(key_sel ^ val_q);
      assign row_hit[r] = &bit_ok;
   end
endmodule

// File: rtl/tcam_entry_fold.sv
module tcam_entry_fold #(
   parameter int ROWS = 32
) (
   input  logic [ROWS-1:0] row_hit,
   input  logic            wide,
   output logic [ROWS-1:0] entry_hit
);
   localparam int HALF = ROWS / 2;

   for (genvar j = 0; j < ROWS; j++) begin : g_ent
      if (j < HALF) begin : g_low
         assign entry_hit[j] = wide ? (row_hit[2*j] & row_hit[2*j+1]) : row_hit[j];
      end else begin : g_high
         assign entry_hit[j] = wide ? 1'b0 : row_hit[j];
      end
   end
endmodule

// File: rtl/tcam_lowest_enc.sv
module tcam_lowest_enc #(
   parameter int N  = 32,
   parameter int AW = 5
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic          multi,
   output logic [AW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = AW'(i);
      end
   end

   assign any   = |vec;
   assign multi = |(vec & (vec - N'(1)));
endmodule

// File: rtl/tcam_pair_search.sv
module tcam_pair_search
   import tcam_pair_pkg::*;
#(
   parameter int ROWS  = 32,
   parameter int KEY_W = 16,
   localparam int AW   = addr_bits(ROWS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wide,
   input  logic               gm_wr_en,
   input  logic [KEY_W-1:0]   gm_wr_data,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [KEY_W-1:0]   wr_value,
   input  logic [KEY_W-1:0]   wr_care,
   input  logic               srch_en,
   input  logic [2*KEY_W-1:0] srch_key,
   output logic               res_valid,
   output logic               res_hit,
   output logic               res_multi,
   output logic [AW-1:0]      res_index,
   output logic               res_flag
);
   if ((KEY_W < 2) || ((KEY_W % 2) != 0)) begin : g_bad_key
      $error("KEY_W must be even and at least 2");
   end
   if ((ROWS < 2) || ((ROWS % 2) != 0)) begin : g_bad_rows
      $error("ROWS must be even and at least 2");
   end

   logic [KEY_W-1:0]   gm_q;
   logic [2*KEY_W-1:0] bit_en;
   logic [ROWS-1:0]    row_hit;
   logic [ROWS-1:0]    entry_hit;
   logic [ROWS-1:0]    match_q;
   logic               s1_valid;
   logic               enc_any;
   logic               enc_multi;
   logic [AW-1:0]      enc_idx;
   flag_phase_e        phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gm_q <= '1;
      else if (gm_wr_en) gm_q <= gm_wr_data;
   end

   tcam_gmask_expand #(.GM_W(KEY_W)) u_gm (
      .gm     (gm_q),
      .bit_en (bit_en)
   );

   tcam_row_bank #(.ROWS(ROWS), .KEY_W(KEY_W), .AW(AW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_value (wr_value),
      .wr_care  (wr_care),
      .key      (srch_key),
      .bit_en   (bit_en),
      .wide     (cfg_wide),
      .row_hit  (row_hit)
   );

   tcam_entry_fold #(.ROWS(ROWS)) u_fold (
      .row_hit   (row_hit),
      .wide      (cfg_wide),
      .entry_hit (entry_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q  <= '0;
         s1_valid <= 1'b0;
      end else begin
         s1_valid <= srch_en;
         if (srch_en) match_q <= entry_hit;
      end
   end

   tcam_lowest_enc #(.N(ROWS), .AW(AW)) u_enc (
      .vec   (match_q),
      .any   (enc_any),
      .multi (enc_multi),
      .idx   (enc_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_hit   <= 1'b0;
         res_multi <= 1'b0;
         res_index <= '0;
         phase_q   <= PH_IDLE;
      end else begin
         if (s1_valid) begin
            res_hit   <= enc_any;
            res_multi <= enc_multi;
            res_index <= enc_any ? enc_idx : '0;
         end
         if (s1_valid)               phase_q <= PH_HIT;
         else if (phase_q == PH_HIT) phase_q <= PH_MULTI;
         else                        phase_q <= PH_IDLE;
      end
   end

   assign res_valid = (phase_q == PH_HIT);

   always_comb begin
      case (phase_q)
         PH_HIT:   res_flag = res_hit;
         PH_MULTI: res_flag = res_multi;
         default:  res_flag = 1'b0;
      endcase
   end
endmodule

// File: rtl/tcam_pair_search_chk.sv
module tcam_pair_search_chk #(
   parameter int ROWS  = 32,
   parameter int KEY_W = 16,
   parameter int AW    = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_wide,
   input logic            srch_en,
   input logic            res_valid,
   input logic            res_hit,
   input logic            res_multi,
   input logic [AW-1:0]   res_index,
   input logic            res_flag,
   input logic [ROWS-1:0] match_q
);
   logic [ROWS-1:0] below;
   always_comb below = (ROWS'(1) << res_index) - ROWS'(1);

   a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(srch_en, 2));
   a_r7_issue: assert property (@(posedge clk) disable iff (!rst_n)
      srch_en |-> ##2 res_valid);
   a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_index == '0 && !res_multi));
   a_r6_multi_hit: assert property (@(posedge clk) disable iff (!rst_n)
      res_multi |-> res_hit);
   a_r9_flag_first: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_flag == res_hit));
   a_r9_flag_second: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_valid && $past(res_valid)) |-> (res_flag == res_multi));
   a_r9_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_valid && !$past(res_valid)) |-> !res_flag);
   a_r5_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit) |-> (($past(match_q) & below) == '0));
   a_r5_winner_set: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit) |-> ((($past(match_q) >> res_index) & ROWS'(1)) != '0));
   a_r10_wide_range: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit && $past(cfg_wide, 2)) |-> (int'(res_index) < ROWS / 2));
endmodule

bind tcam_pair_search tcam_pair_search_chk #(.ROWS(ROWS), .KEY_W(KEY_W), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wide  (cfg_wide),
   .srch_en   (srch_en),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .res_multi (res_multi),
   .res_index (res_index),
   .res_flag  (res_flag),
   .match_q   (match_q)
);

// File: tb/sim_tcam_pair_search.sv
module sim_tcam_pair_search;
   localparam int ROWS  = 32;
   localparam int KEY_W = 16;
   localparam int AW    = 5;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_wide = 1'b0;
   logic               gm_wr_en = 1'b0;
   logic [KEY_W-1:0]   gm_wr_data = '0;
   logic               wr_en = 1'b0;
   logic [AW-1:0]      wr_addr = '0;
   logic [KEY_W-1:0]   wr_value = '0;
   logic [KEY_W-1:0]   wr_care = '0;
   logic               srch_en = 1'b0;
   logic [2*KEY_W-1:0] srch_key = '0;
   logic               res_valid, res_hit, res_multi, res_flag;
   logic [AW-1:0]      res_index;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tcam_pair_search #(.ROWS(ROWS), .KEY_W(KEY_W)) u0 (
      .clk, .rst_n, .cfg_wide, .gm_wr_en, .gm_wr_data, .wr_en, .wr_addr,
      .wr_value, .wr_care, .srch_en, .srch_key, .res_valid, .res_hit,
      .res_multi, .res_index, .res_flag
   );

   task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", what, got, exp);
      end
   endtask

   task automatic write_row(input int r, input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] c);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(r); wr_value = v; wr_care = c;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_gm(input logic [KEY_W-1:0] m);
      @(negedge clk);
      gm_wr_en = 1'b1; gm_wr_data = m;
      @(negedge clk);
      gm_wr_en = 1'b0;
   endtask

   task automatic search(input logic [2*KEY_W-1:0] key, input logic wide,
                         input logic eh, input int ei, input logic em, input string tag);
      @(negedge clk);
      srch_en = 1'b1; srch_key = key; cfg_wide = wide;
      @(negedge clk);
      srch_en = 1'b0;
      chk({tag, " R7 no early valid"}, 32'(res_valid), 32'd0);
      @(negedge clk);
      chk({tag, " R7 valid"}, 32'(res_valid), 32'd1);
      chk({tag, " hit"}, 32'(res_hit), 32'(eh));
      chk({tag, " index"}, 32'(res_index), 32'(ei));
      chk({tag, " multi"}, 32'(res_multi), 32'(em));
      chk({tag, " R9 flag=hit"}, 32'(res_flag), 32'(eh));
      @(negedge clk);
      chk({tag, " R7 valid drops"}, 32'(res_valid), 32'd0);
      chk({tag, " R9 flag=multi"}, 32'(res_flag), 32'(em));
   endtask

   task automatic t_reset;
      chk("R11 reset valid", 32'(res_valid), 0);
      chk("R11 reset hit", 32'(res_hit), 0);
      chk("R11 reset flag", 32'(res_flag), 0);
      search(32'h0, 1'b0, 1'b1, 0, 1'b1, "R11 rows reset to zero");
      search(32'h1, 1'b0, 1'b0, 0, 1'b0, "R8 miss after reset");
   endtask

   task automatic t_load;
      for (int r = 0; r < ROWS; r++) write_row(r, 16'hA500 | 16'(r), 16'hFFFF);
      search(32'hA503, 1'b0, 1'b1, 3, 1'b0, "R1 exact row 3");
      search(32'hFFFF_A51F, 1'b0, 1'b1, 31, 1'b0, "R10 narrow ignores upper key");
   endtask

   task automatic t_wildcard;
      write_row(10, 16'h5A00, 16'hFF00);
      search(32'h5A77, 1'b0, 1'b1, 10, 1'b0, "R2 wildcard low byte");
      search(32'h5B77, 1'b0, 1'b0, 0, 1'b0, "R8 R2 cared bit differs");
   endtask

   task automatic t_priority;
      write_row(25, 16'h1234, 16'hFFFF);
      write_row(20, 16'h1234, 16'hFFFF);
      search(32'h1234, 1'b0, 1'b1, 20, 1'b1, "R5 R6 lowest of two");
   endtask

   task automatic t_pair_mask;
      set_gm(16'hFFFE);
      search(32'hA502, 1'b0, 1'b1, 0, 1'b1, "R3 pair 0 excluded");
      search(32'hA504, 1'b0, 1'b1, 4, 1'b1, "R3 pair 1 still compared");
      set_gm(16'hFFFF);
      search(32'hA502, 1'b0, 1'b1, 2, 1'b0, "R3 mask restored");
   endtask

   task automatic t_write_under_mask;
      set_gm(16'h0000);
      search(32'h0BAD, 1'b0, 1'b1, 0, 1'b1, "R3 all pairs excluded");
      write_row(30, 16'hC3C3, 16'hFFFF);
      set_gm(16'hFFFF);
      search(32'hC3C3, 1'b0, 1'b1, 30, 1'b0, "R4 write ignores mask");
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(5); wr_value = 16'h7777; wr_care = 16'hFFFF;
      srch_en = 1'b1; srch_key = 32'h7777; cfg_wide = 1'b0;
      @(negedge clk);
      wr_en = 1'b0; srch_en = 1'b0;
      @(negedge clk);
      chk("R12 valid", 32'(res_valid), 1);
      chk("R12 old contents miss", 32'(res_hit), 0);
      search(32'h7777, 1'b0, 1'b1, 5, 1'b0, "R12 new contents");
   endtask

   task automatic t_wide;
      write_row(12, 16'h1111, 16'hFFFF);
      write_row(13, 16'h2222, 16'hFFFF);
      search(32'h2222_1111, 1'b1, 1'b1, 6, 1'b0, "R10 wide pair entry 6");
      search(32'h2223_1111, 1'b1, 1'b0, 0, 1'b0, "R10 wide high half miss");
      set_gm(16'hFEFF);
      search(32'h2221_1111, 1'b1, 1'b1, 6, 1'b0, "R10 R3 wide upper mask bit");
      set_gm(16'hFFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_load;
      t_wildcard;
      t_priority;
      t_pair_mask;
      t_write_under_mask;
      t_same_cycle;
      t_wide;
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule